// File: doc/BRIEF.md
# SDRAM Bank State and Command Timing Monitor

This block sits passively on an SDRAM command bus and watches every command the controller issues. It decodes the chip-select, row-strobe, column-strobe and write-enable pins into a command, and it keeps a small state machine per bank: idle, opening, open, bursting a read or write, in a read or write that closes itself afterwards, and precharging. It also remembers the row opened in each bank and whether a refresh is still running. It drives nothing back onto the bus.

Each command is judged against the state of the bank it addresses and against cycle counters kept per bank and across banks. These counters cover the gap from activate to column command, from activate to precharge, from precharge to activate, between activates to one bank, between activates to different banks, and from write data to precharge. When a command breaks a rule, the monitor raises a one-cycle error pulse carrying a reason code and a bank number. It then goes on tracking as though the command had been accepted, so one mistake does not set off a flood of errors after it. All timing limits are parameters counted in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset every bank reads idle (state code 0), no error is flagged and the refresh flag is low. Bank state codes are: 0 idle, 1 opening, 2 open, 3 reading, 4 writing, 5 read with auto-close, 6 write with auto-close, 7 precharging.
- R2: An activate (cs_n,ras_n,cas_n,we_n = 0,0,1,1) moves the bank selected by `ba` to state 1 and stores `addr` as its open row. The bank moves to state 2 once T_RCD cycles have passed since the activate.
- R3: An activate to a bank in states 1 to 6 gives error code 1. An activate to a bank that is precharging, fewer than T_RP cycles after the precharge, gives code 4. An activate fewer than T_RC cycles after the previous activate to the same bank gives code 3. When several apply, the first one in this list is reported.
- R4: An activate fewer than T_RRD cycles after any earlier activate gives code 2, unless the bank itself already has an error.
- R5: A read (0,1,0,1) or write (0,1,0,0) to a bank that is idle or precharging gives code 5 and changes nothing. A read or write fewer than T_RCD cycles after that bank's activate gives code 6.
- R6: A read or write with addr[10] low holds the bank in state 3 or 4 for BURST_LEN cycles, then returns it to state 2. With addr[10] high, a read holds state 5 for BURST_LEN cycles and a write holds state 6 for BURST_LEN-1+T_DPL cycles. In both cases the bank then spends T_RP cycles in state 7 and returns to state 0.
- R7: A read, write or precharge to a bank in state 5 or 6 gives code 7.
- R8: A precharge (0,0,1,0) addresses the bank on `ba` when addr[10] is low and every bank when addr[10] is high. An opened bank goes to state 7 for T_RP cycles and then to state 0. A precharge to an idle or precharging bank has no effect and raises no error.
- R9: A precharge to an open bank fewer than T_RAS cycles after its activate gives code 8. Otherwise, a precharge fewer than BURST_LEN-1+T_DPL cycles after that bank's last write command gives code 9.
- R10: A refresh (0,0,0,1) or mode-register set (0,0,0,0) while any bank is not idle gives code 10.
- R11: A refresh sets `refreshing` for T_RC cycles. Any command other than no-op or deselect during that time gives code 11, and this code takes priority over all other codes.
- R12: A bank that stays opened (states 1 to 6) for T_RAS_MAX+1 cycles after its activate raises code 12 once, naming that bank, provided no command error is reported in the same cycle.
- R13: An error appears on `err_valid`/`err_code`/`err_bank` for exactly the one cycle after the offending command. Among bank errors the lowest bank wins. Refresh-related and spacing errors report the `ba` pins as the bank. The state is updated as though the command had been accepted.
- R14: With cs_n high, the command pins are ignored: no state changes and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Address bus; bit 10 selects auto-close or all banks |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Violation reason code |
| err_bank | output | BA_W | Bank blamed for the violation |
| bank_state | output | NB*3 | Per-bank state code, bank i at bits 3i+2:3i |
| open_row | output | NB*ROW_W | Row opened in each bank, bank i at slice i |
| refreshing | output | 1 | High while a refresh interval runs |

## Verification
The bench builds the monitor with four banks, a burst of four, and the nominal spacing of two cycles for the activate-to-column, precharge, bank-to-bank and write-recovery gaps. It raises T_RC to 9 so that the same-bank activate spacing exceeds T_RAS plus T_RP, which makes a tRC-only violation reachable. It lowers T_RAS_MAX to 30 so the open-row timeout fires within a few dozen cycles. Each spacing rule is swept across the gaps just below and just above its limit, with the expected error computed from the gap. Directed sequences then cover the auto-close timelines, the all-bank precharge arbitration and the refresh window.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_RD      = 3'd3,
        BK_WR      = 3'd4,
        BK_RD_AP   = 3'd5,
        BK_WR_AP   = 3'd6,
        BK_PRECH   = 3'd7
    } bank_st_e;

    typedef enum logic [2:0] {
        C_DESL, C_NOP, C_READ, C_WRITE, C_ACT, C_PRE, C_REF, C_MRS
    } cmd_e;

    typedef enum logic [3:0] {
        E_NONE      = 4'd0,
        E_ACT_OPEN  = 4'd1,
        E_RRD       = 4'd2,
        E_RC        = 4'd3,
        E_RP        = 4'd4,
        E_NOT_OPEN  = 4'd5,
        E_RCD       = 4'd6,
        E_AP_BUSY   = 4'd7,
        E_RAS       = 4'd8,
        E_DPL       = 4'd9,
        E_NOT_IDLE  = 4'd10,
        E_REF_BUSY  = 4'd11,
        E_RAS_MAX   = 4'd12
    } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = C_DESL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b101:  cmd = C_READ;
                3'b100:  cmd = C_WRITE;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                3'b000:  cmd = C_MRS;
                default: cmd = C_NOP; // burst stop: no bank effect tracked
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_mon_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int CNT_W     = 15,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_DPL     = 2,
    parameter int T_RAS_MAX = 12000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             hit,
    input  logic             auto_close,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row,
    output err_e             cmd_err,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] K_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] K_BL   = CNT_W'(BURST_LEN);
    localparam logic [CNT_W-1:0] K_RCD  = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] K_RP   = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] K_RAS  = CNT_W'(T_RAS);
    localparam logic [CNT_W-1:0] K_RC   = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] K_WREC = CNT_W'(BURST_LEN - 1 + T_DPL);
    localparam logic [CNT_W-1:0] K_TMO  = CNT_W'(T_RAS_MAX + 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] since_act;
        logic [CNT_W-1:0] since_wr;
        logic [ROW_W-1:0] row;
    } trk_t;

    trk_t trk_d, trk_q;
    logic is_open, is_ap;

    always_comb begin
        trk_d     = trk_q;
        cmd_err   = E_NONE;
        is_open   = trk_q.st inside {BK_OPENING, BK_OPEN, BK_RD, BK_WR};
        is_ap     = trk_q.st inside {BK_RD_AP, BK_WR_AP};
        timeout   = (is_open || is_ap) && (trk_q.since_act == K_TMO);

        trk_d.cnt       = (&trk_q.cnt)       ? trk_q.cnt       : trk_q.cnt + K_ONE;
        trk_d.since_act = (&trk_q.since_act) ? trk_q.since_act : trk_q.since_act + K_ONE;
        trk_d.since_wr  = (&trk_q.since_wr)  ? trk_q.since_wr  : trk_q.since_wr + K_ONE;

        // autonomous progress of the bank
        unique case (trk_q.st)
            BK_OPENING: if (trk_d.since_act >= K_RCD) trk_d.st = BK_OPEN;
            BK_RD, BK_WR: if (trk_q.cnt >= K_BL) trk_d.st = BK_OPEN;
            BK_RD_AP: if (trk_q.cnt >= K_BL) begin
                trk_d.st  = BK_PRECH;
                trk_d.cnt = K_ONE;
            end
            BK_WR_AP: if (trk_q.cnt >= K_WREC) begin
                trk_d.st  = BK_PRECH;
                trk_d.cnt = K_ONE;
            end
            BK_PRECH: if (trk_q.cnt >= K_RP) trk_d.st = BK_IDLE;
            default: ;
        endcase

        // command addressed to this bank
        if (hit) begin
            unique case (cmd)
                C_ACT: begin
                    if (is_open || is_ap)                           cmd_err = E_ACT_OPEN;
                    else if (trk_q.st == BK_PRECH && trk_q.cnt < K_RP) cmd_err = E_RP;
                    else if (trk_q.since_act < K_RC)                cmd_err = E_RC;
                    trk_d.st        = (K_ONE >= K_RCD) ? BK_OPEN : BK_OPENING;
                    trk_d.since_act = K_ONE;
                    trk_d.row       = row_in;
                end
                C_READ, C_WRITE: begin
                    if (is_ap)         cmd_err = E_AP_BUSY;
                    else if (!is_open) cmd_err = E_NOT_OPEN;
                    else begin
                        if (trk_q.since_act < K_RCD) cmd_err = E_RCD;
                        if (cmd == C_READ) trk_d.st = auto_close ? BK_RD_AP : BK_RD;
                        else begin
                            trk_d.st       = auto_close ? BK_WR_AP : BK_WR;
                            trk_d.since_wr = K_ONE;
                        end
                        trk_d.cnt = K_ONE;
                    end
                end
                C_PRE: begin
                    if (is_ap) begin
                        cmd_err   = E_AP_BUSY;
                        trk_d.st  = BK_PRECH;
                        trk_d.cnt = K_ONE;
                    end else if (is_open) begin
                        if (trk_q.since_act < K_RAS)      cmd_err = E_RAS;
                        else if (trk_q.since_wr < K_WREC) cmd_err = E_DPL;
                        trk_d.st  = BK_PRECH;
                        trk_d.cnt = K_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.st        <= BK_IDLE;
            trk_q.cnt       <= '1;
            trk_q.since_act <= '1;
            trk_q.since_wr  <= '1;
            trk_q.row       <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign st  = trk_q.st;
    assign row = trk_q.row;

    // R8
    prech_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == BK_PRECH && !(hit && cmd == C_ACT))
        |=> (trk_q.st == BK_PRECH || trk_q.st == BK_IDLE));

    // R14
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == BK_IDLE && !(hit && cmd == C_ACT)) |=> (trk_q.st == BK_IDLE));

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && cmd == C_ACT) |=> $stable(trk_q.row));

    // R5
    closed_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (cmd == C_READ || cmd == C_WRITE) && trk_q.st == BK_IDLE)
        |=> (trk_q.st == BK_IDLE));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NB        = 4,
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_DPL     = 2,
    parameter int T_RAS_MAX = 12000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [$clog2(NB)-1:0] ba,
    input  logic [ROW_W-1:0]      addr,
    output logic                  err_valid,
    output logic [3:0]            err_code,
    output logic [$clog2(NB)-1:0] err_bank,
    output logic [NB*3-1:0]       bank_state,
    output logic [NB*ROW_W-1:0]   open_row,
    output logic                  refreshing
);
    localparam int BA_W   = $clog2(NB);
    localparam int AP_BIT = 10;
    localparam int CNT_W  = $clog2(T_RAS_MAX + T_RC + 2) + 1;
    localparam logic [CNT_W-1:0] K_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] K_RRD = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0] K_RC  = CNT_W'(T_RC);

    typedef struct packed {
        logic [CNT_W-1:0] since_act;
        logic [CNT_W-1:0] ref_cnt;
        logic             err_v;
        err_e             code;
        logic [BA_W-1:0]  bank;
    } glob_t;

    glob_t     g_d, g_q;
    cmd_e      cmd;
    bank_st_e  bst      [NB];
    err_e      bank_err [NB];
    logic [NB-1:0] tmo, hit, idle_v;
    logic      busy;

    sdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign hit[i] = ((cmd == C_ACT || cmd == C_READ || cmd == C_WRITE) && ba == BA_W'(i))
                      || (cmd == C_PRE && (ba == BA_W'(i) || addr[AP_BIT]));
        sdram_bank_track #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD),
            .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_DPL(T_DPL), .T_RAS_MAX(T_RAS_MAX)
        ) u_trk (
            .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(hit[i]), .auto_close(addr[AP_BIT]),
            .row_in(addr), .st(bst[i]), .row(open_row[i*ROW_W +: ROW_W]),
            .cmd_err(bank_err[i]), .timeout(tmo[i])
        );
        assign bank_state[i*3 +: 3] = bst[i];
        assign idle_v[i]            = (bst[i] == BK_IDLE);
    end

    assign busy = (g_q.ref_cnt < K_RC);

    always_comb begin
        g_d           = g_q;
        g_d.since_act = (&g_q.since_act) ? g_q.since_act : g_q.since_act + K_ONE;
        g_d.ref_cnt   = (&g_q.ref_cnt)   ? g_q.ref_cnt   : g_q.ref_cnt + K_ONE;
        if (cmd == C_ACT) g_d.since_act = K_ONE;
        if (cmd == C_REF) g_d.ref_cnt   = K_ONE;

        g_d.code = E_NONE;
        g_d.bank = ba;
        for (int i = NB - 1; i >= 0; i--) begin
            if (bank_err[i] != E_NONE) begin
                g_d.code = bank_err[i];
                g_d.bank = BA_W'(i);
            end
        end
        if (g_d.code == E_NONE && cmd == C_ACT && g_q.since_act < K_RRD) begin
            g_d.code = E_RRD;
            g_d.bank = ba;
        end
        if (g_d.code == E_NONE) begin
            for (int i = NB - 1; i >= 0; i--) begin
                if (tmo[i]) begin
                    g_d.code = E_RAS_MAX;
                    g_d.bank = BA_W'(i);
                end
            end
        end
        if ((cmd == C_REF || cmd == C_MRS) && !(&idle_v)) begin
            g_d.code = E_NOT_IDLE;
            g_d.bank = ba;
        end
        if (busy && cmd != C_NOP && cmd != C_DESL) begin
            g_d.code = E_REF_BUSY;
            g_d.bank = ba;
        end
        g_d.err_v = (g_d.code != E_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.since_act <= '1;
            g_q.ref_cnt   <= '1;
            g_q.err_v     <= 1'b0;
            g_q.code      <= E_NONE;
            g_q.bank      <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign err_valid  = g_q.err_v;
    assign err_code   = g_q.code;
    assign err_bank   = g_q.bank;
    assign refreshing = busy;

    // R13
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 4'd0));

    // R11
    ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refreshing && cmd != C_NOP && cmd != C_DESL)
        |=> (err_valid && err_code == 4'(E_REF_BUSY)));

    // R10
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refreshing && (cmd == C_REF || cmd == C_MRS) && !(&idle_v)) |=> err_valid);

    // R14
    desl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !refreshing && (&idle_v)) |=> (&idle_v));
endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
    localparam int CLK_NS = 10;
    localparam logic [3:0] P_NOP = 4'b0111, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_ACT = 4'b0011, P_PRE = 4'b0010, P_REF = 4'b0001,
                           P_MRS = 4'b0000;
    localparam int AP = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        err_valid, refreshing;
    logic [3:0]  err_code;
    logic [1:0]  err_bank;
    logic [11:0] bank_state;
    logic [51:0] open_row;
    int checks = 0, fails = 0;

    sdram_cmd_monitor #(
        .NB(4), .ROW_W(13), .BURST_LEN(4), .T_RRD(2), .T_RCD(2), .T_RP(2),
        .T_RAS(5), .T_RC(9), .T_DPL(2), .T_RAS_MAX(30)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .err_valid(err_valid), .err_code(err_code),
        .err_bank(err_bank), .bank_state(bank_state), .open_row(open_row),
        .refreshing(refreshing)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic put(input logic [3:0] c, input int b, input int a);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = 2'(b);
        addr = 13'(a);
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) put(P_NOP, 0, 0);
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_err(input string tag, input int code, input int bank);
        chk_eq(tag, err_valid ? int'(err_code) : 0, code);
        if (code != 0) chk_eq({tag, " bank"}, int'(err_bank), bank);
    endtask

    function automatic int st(input int b);
        return int'(bank_state[b*3 +: 3]);
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        put(P_NOP, 0, 0);
        // R1 reset state
        for (int b = 0; b < 4; b++) chk_eq("R1 reset bank state", st(b), 0);
        chk_eq("R1 reset err", int'(err_valid), 0);
        chk_eq("R1 reset refreshing", int'(refreshing), 0);

        // R5 activate-to-column sweep
        for (int k = 1; k <= 3; k++) begin
            put(P_ACT, 0, 5);
            nop(k - 1);
            put(P_RD, 0, 0);
            expect_err("R5 tRCD sweep", (k < 2) ? 6 : 0, 0);
            nop(8);
            put(P_PRE, 0, 0);
            expect_err("R8 precharge after read", 0, 0);
            nop(2);
            chk_eq("R8 idle after precharge", st(0), 0);
            nop(1);
        end

        // R9 activate-to-precharge sweep
        for (int k = 3; k <= 6; k++) begin
            put(P_ACT, 0, 9);
            nop(k - 1);
            put(P_PRE, 0, 0);
            expect_err("R9 tRAS sweep", (k < 5) ? 8 : 0, 0);
            nop(5);
            chk_eq("R9 idle after sweep", st(0), 0);
        end

        // R4 bank-to-bank activate sweep
        for (int k = 1; k <= 3; k++) begin
            put(P_ACT, 0, 1);
            nop(k - 1);
            put(P_ACT, 1, 2);
            expect_err("R4 tRRD sweep", (k < 2) ? 2 : 0, 1);
            nop(6);
            put(P_PRE, 0, AP);
            expect_err("R8 all-bank precharge", 0, 0);
            nop(5);
            chk_eq("R8 all-bank idle b0", st(0), 0);
            chk_eq("R8 all-bank idle b1", st(1), 0);
        end

        // R3 precharge-to-activate sweep
        for (int k = 1; k <= 3; k++) begin
            put(P_ACT, 2, 3);
            nop(6);
            put(P_PRE, 2, 0);
            nop(k - 1);
            put(P_ACT, 2, 4);
            expect_err("R3 tRP sweep", (k < 2) ? 4 : 0, 2);
            nop(6);
            put(P_PRE, 2, 0);
            nop(5);
        end

        // R3 same-bank activate spacing sweep
        for (int k = 2; k <= 5; k++) begin
            put(P_ACT, 3, 3);
            nop(4);
            put(P_PRE, 3, 0);
            nop(k - 1);
            put(P_ACT, 3, 4);
            expect_err("R3 tRC sweep", (k < 4) ? 3 : 0, 3);
            nop(6);
            put(P_PRE, 3, 0);
            nop(5);
        end

        // R9 write recovery sweep
        for (int k = 3; k <= 6; k++) begin
            put(P_ACT, 0, 6);
            nop(4);
            put(P_WR, 0, 0);
            expect_err("R9 write accepted", 0, 0);
            nop(k - 1);
            put(P_PRE, 0, 0);
            expect_err("R9 tDPL sweep", (k < 5) ? 9 : 0, 0);
            nop(5);
            chk_eq("R9 idle after write", st(0), 0);
        end

        // R2 activate and row capture
        put(P_ACT, 3, 'h1ABC);
        expect_err("R2 activate", 0, 0);
        chk_eq("R2 opening state", st(3), 1);
        chk_eq("R2 open row", int'(open_row[39 +: 13]), 'h1ABC);
        nop(1);
        chk_eq("R2 open state", st(3), 2);
        // R3 activate an opened bank; R13 takes effect anyway
        put(P_ACT, 3, 5);
        expect_err("R3 activate open bank", 1, 3);
        chk_eq("R13 row replaced", int'(open_row[39 +: 13]), 5);
        nop(1);
        // R5 read of idle bank
        put(P_RD, 1, 0);
        expect_err("R5 read idle bank", 5, 1);
        chk_eq("R5 idle bank unchanged", st(1), 0);
        // R6 plain read timeline
        put(P_RD, 3, 0);
        expect_err("R6 read", 0, 0);
        chk_eq("R6 reading state", st(3), 3);
        nop(3);
        chk_eq("R6 reading last cycle", st(3), 3);
        nop(1);
        chk_eq("R6 back to open", st(3), 2);
        // R6 write with auto-close, R7 access during it
        put(P_WR, 3, AP);
        expect_err("R6 write auto-close", 0, 0);
        chk_eq("R6 write auto-close state", st(3), 6);
        put(P_RD, 3, 0);
        expect_err("R7 read during auto-close", 7, 3);
        nop(3);
        chk_eq("R6 write auto-close held", st(3), 6);
        nop(1);
        chk_eq("R6 write auto-close precharging", st(3), 7);
        nop(1);
        chk_eq("R6 still precharging", st(3), 7);
        nop(1);
        chk_eq("R6 idle after auto-close", st(3), 0);

        // R6 read with auto-close; R8 precharge during precharging is quiet
        put(P_ACT, 0, 7);
        nop(1);
        put(P_RD, 0, AP);
        chk_eq("R6 read auto-close state", st(0), 5);
        put(P_PRE, 0, 0);
        expect_err("R7 precharge during auto-close", 7, 0);
        chk_eq("R7 precharge forced", st(0), 7);
        nop(5);
        put(P_ACT, 0, 7);
        nop(1);
        put(P_RD, 0, AP);
        nop(3);
        chk_eq("R6 read auto-close held", st(0), 5);
        nop(1);
        chk_eq("R6 read auto-close precharging", st(0), 7);
        put(P_PRE, 0, 0);
        expect_err("R8 precharge while precharging", 0, 0);
        nop(3);
        chk_eq("R6 read auto-close idle", st(0), 0);

        // R8 precharge of idle bank
        put(P_PRE, 1, 0);
        expect_err("R8 precharge idle bank", 0, 0);
        chk_eq("R8 idle bank stays idle", st(1), 0);
        // R14 deselect with an activate pattern
        put(4'b1011, 1, 7);
        expect_err("R14 deselect ignored", 0, 0);
        chk_eq("R14 deselect no state change", st(1), 0);
        nop(9);

        // R13 all-bank precharge blames lowest bank, still takes effect
        put(P_ACT, 1, 1);
        nop(1);
        put(P_ACT, 3, 2);
        nop(1);
        put(P_PRE, 0, AP);
        expect_err("R13 lowest bank reported", 8, 1);
        chk_eq("R13 bank1 precharging", st(1), 7);
        chk_eq("R13 bank3 precharging", st(3), 7);
        nop(9);

        // R10 refresh with a bank open
        put(P_ACT, 1, 1);
        nop(1);
        put(P_REF, 0, 0);
        expect_err("R10 refresh with open bank", 10, 0);
        nop(8);
        put(P_PRE, 1, 0);
        expect_err("R10 precharge after window", 0, 0);
        nop(3);

        // R11 refresh window
        put(P_REF, 0, 0);
        expect_err("R11 refresh accepted", 0, 0);
        chk_eq("R11 refreshing set", int'(refreshing), 1);
        put(P_RD, 0, 0);
        expect_err("R11 command during refresh", 11, 0);
        nop(6);
        chk_eq("R11 refreshing last cycle", int'(refreshing), 1);
        nop(1);
        chk_eq("R11 refreshing cleared", int'(refreshing), 0);
        put(P_MRS, 0, 0);
        expect_err("R10 mode set all idle", 0, 0);
        nop(2);

        // R12 open-row timeout
        put(P_ACT, 2, 8);
        nop(30);
        expect_err("R12 no timeout yet", 0, 0);
        nop(1);
        expect_err("R12 timeout", 12, 2);
        nop(1);
        expect_err("R12 single pulse", 0, 0);
        put(P_PRE, 2, 0);
        nop(3);
        chk_eq("R12 bank closed", st(2), 0);

        report();
    end
endmodule